// File: doc/BRIEF.md
# Segmented-Paged Address Translator

This block turns a virtual address into a physical address in two steps. The virtual address has three fields. From most to least significant they are the segment number, the virtual page number and the byte displacement. The segment number picks one entry of a small on-chip segment table. Each entry holds three things: the byte address of that segment's page table in memory, the highest page number the segment may use, and a valid flag. The translator checks the page number against that limit. It then forms the address of the page-table entry as the base plus the page number times the entry size. It fetches the entry through a memory read port that uses a request/acknowledge handshake.

The fetched entry supplies a physical page number. A per-request mode selects how that number is combined with the displacement: placed above it, or scaled and added to it. A missing segment, an out-of-range page or an invalid page-table entry ends the walk with a one-cycle fault pulse and a cause code. The faulting virtual address is kept for later inspection. Fields are split purely by bit position. An address whose page arithmetic carried into the segment field is translated through the next segment, with no complaint.

The segment table is filled through a simple write port. A request is taken only while the block reports itself ready.

Top module: `segpage_xlat`

## Requirements
- R1: After reset, ready=1, done=0, fault=0, mem_req=0 and fault_cause=0.
- R2: req_vaddr is split as {segment[15:14], page[13:8], displacement[7:0]} with default parameters. No check spans fields: an address whose page field overflowed into the segment field is translated through the segment now named by bits [15:14].
- R3: The page-table entry address driven on mem_addr equals the segment's base plus page × PTE_BYTES (default 2).
- R4: Once mem_req rises, mem_req and mem_addr stay unchanged until the cycle in which mem_ack is sampled high, for any number of wait cycles.
- R5: With req_mode=0, paddr = {ppn, displacement}, where ppn is mem_rdata[14:0] of the fetched entry.
- R6: With req_mode=1, paddr = ppn × 16 + displacement.
- R7: A segment entry whose valid flag is clear ends the request with fault=1 and fault_cause=1, and no memory read is issued.
- R8: A page number greater than the segment's limit ends the request with fault=1 and fault_cause=2, and no memory read is issued. A page equal to the limit translates normally.
- R9: A fetched entry whose bit 15 (valid) is 0 ends the request with fault=1 and fault_cause=3.
- R10: fault_vaddr takes the faulting request's virtual address when fault is raised, and holds it through later successful translations.
- R11: A request is accepted only while ready=1. req_valid held high while a walk is in progress starts no second walk.
- R12: A segment table write (tbl_wr_en with index, base, limit, valid) takes effect for every later translation through that segment.
- R13: done and fault are each a single-cycle pulse. done rises the cycle after mem_ack is sampled. A segment or bounds fault is visible two clock edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Write one segment table entry |
| tbl_wr_idx | input | SEG_W | Entry index to write |
| tbl_wr_base | input | MEM_AW | Page-table base byte address |
| tbl_wr_limit | input | PAGE_W | Highest permitted page number |
| tbl_wr_valid | input | 1 | Entry valid flag |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | SEG_W+PAGE_W+DISP_W | Virtual address to translate |
| req_mode | input | 1 | 0 = place page above displacement, 1 = scaled add |
| ready | output | 1 | Idle and able to accept a request |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | MEM_AW | Page-table entry address |
| mem_ack | input | 1 | Read acknowledge, data valid with it |
| mem_rdata | input | MEM_DW | Page-table entry {valid, ppn} |
| done | output | 1 | Translation complete, paddr valid |
| paddr | output | MEM_DW-1+DISP_W | Physical address |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | 1 segment, 2 bounds, 3 page, 0 none |
| fault_vaddr | output | SEG_W+PAGE_W+DISP_W | Virtual address of the last fault |

## Verification
A controller stuck in a waiting state shows as a missing done or fault pulse within a few cycles of acceptance, or as mem_req staying high after its acknowledge. A wrongly chosen segment entry or a mis-scaled page index appears at once on mem_addr during the first request cycle. A combine error appears on paddr in the done cycle. A broken limit compare shows as a memory read issued, or a fault with cause 2 raised, on exactly the boundary pages. A fault register that is overwritten without cause shows as fault_vaddr changing across a clean translation.

// File: rtl/segpage_xlat_pkg.sv
`timescale 1ns/1ps
package segpage_xlat_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_SEG    = 2'd1,
      CAUSE_BOUNDS = 2'd2,
      CAUSE_PAGE   = 2'd3
   } xlat_cause_e;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_SEG      = 3'd1,
      ST_PT_REQ   = 3'd2,
      ST_PT_WAIT  = 3'd3,
      ST_DONE     = 3'd4,
      ST_FAULT    = 3'd5
   } xlat_state_e;
endpackage

// File: rtl/sp_seg_table.sv
`timescale 1ns/1ps
module sp_seg_table #(
   parameter int SEG_W  = 2,
   parameter int PAGE_W = 6,
   parameter int BASE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEG_W-1:0]  wr_idx,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [PAGE_W-1:0] wr_limit,
   input  logic              wr_valid,
   input  logic [SEG_W-1:0]  rd_idx,
   output logic [BASE_W-1:0] rd_base,
   output logic [PAGE_W-1:0] rd_limit,
   output logic              rd_valid
);
   localparam int N_SEG = 1 << SEG_W;

   logic [BASE_W-1:0] base_q  [N_SEG];
   logic [PAGE_W-1:0] limit_q [N_SEG];
   logic [N_SEG-1:0]  valid_q;

   for (genvar g = 0; g < N_SEG; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[g]  <= '0;
            limit_q[g] <= '0;
            valid_q[g] <= 1'b0;
         end else if (wr_en && (wr_idx == SEG_W'(g))) begin
            base_q[g]  <= wr_base;
            limit_q[g] <= wr_limit;
            valid_q[g] <= wr_valid;
         end
      end
   end

   assign rd_base  = base_q[rd_idx];
   assign rd_limit = limit_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];

   // R12: a write lands in the addressed entry by the next cycle
   a_r12_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_idx == wr_idx) |=> (rd_idx != $past(wr_idx)) ||
         (rd_valid == $past(wr_valid) && rd_base == $past(wr_base)));
endmodule

// File: rtl/sp_addr_calc.sv
`timescale 1ns/1ps
module sp_addr_calc #(
   parameter int PAGE_W      = 6,
   parameter int DISP_W      = 8,
   parameter int BASE_W      = 16,
   parameter int PPN_W       = 15,
   parameter int PTE_BYTES   = 2,
   parameter int FRAME_SHIFT = 4
) (
   input  logic [BASE_W-1:0]       pt_base,
   input  logic [PAGE_W-1:0]       vpage,
   input  logic [DISP_W-1:0]       disp,
   input  logic [PPN_W-1:0]        ppn,
   input  logic                    add_mode,
   output logic [BASE_W-1:0]       pte_addr,
   output logic [PPN_W+DISP_W-1:0] paddr
);
   localparam int PA_W = PPN_W + DISP_W;
   localparam bit PTE_POW2 = (PTE_BYTES & (PTE_BYTES - 1)) == 0;

   logic [BASE_W-1:0] page_off;

   if (PTE_POW2) begin : g_shift
      localparam int SH = $clog2(PTE_BYTES);
      assign page_off = BASE_W'(vpage) << SH;
   end else begin : g_mult
      assign page_off = BASE_W'(vpage) * BASE_W'(PTE_BYTES);
   end

   assign pte_addr = pt_base + page_off;

   logic [PA_W-1:0] pa_cat;
   logic [PA_W-1:0] pa_add;
   assign pa_cat = {ppn, disp};
   assign pa_add = (PA_W'(ppn) << FRAME_SHIFT) + PA_W'(disp);
   assign paddr  = add_mode ? pa_add : pa_cat;
endmodule

// File: rtl/sp_walk_ctrl.sv
`timescale 1ns/1ps
module sp_walk_ctrl
   import segpage_xlat_pkg::*;
#(
   parameter int SEG_W  = 2,
   parameter int PAGE_W = 6,
   parameter int DISP_W = 8,
   parameter int MEM_AW = 16,
   parameter int MEM_DW = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   input  logic [SEG_W+PAGE_W+DISP_W-1:0] req_vaddr,
   input  logic                           req_mode,
   input  logic                           seg_valid,
   input  logic [PAGE_W-1:0]              seg_limit,
   input  logic [MEM_AW-1:0]              pte_addr,
   input  logic                           mem_ack,
   input  logic [MEM_DW-1:0]              mem_rdata,
   output logic                           ready,
   output logic [SEG_W+PAGE_W+DISP_W-1:0] cur_vaddr,
   output logic                           cur_mode,
   output logic                           mem_req,
   output logic [MEM_AW-1:0]              mem_addr,
   output logic [MEM_DW-2:0]              ppn,
   output logic                           done,
   output logic                           fault,
   output logic [1:0]                     fault_cause,
   output logic [SEG_W+PAGE_W+DISP_W-1:0] fault_vaddr
);
   localparam int VA_W = SEG_W + PAGE_W + DISP_W;

   xlat_state_e       state_q;
   xlat_cause_e       cause_q;
   logic [PAGE_W-1:0] vpage;

   assign vpage = cur_vaddr[DISP_W +: PAGE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cause_q     <= CAUSE_NONE;
         cur_vaddr   <= '0;
         cur_mode    <= 1'b0;
         mem_addr    <= '0;
         ppn         <= '0;
         fault_vaddr <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               cur_vaddr <= req_vaddr;
               cur_mode  <= req_mode;
               state_q   <= ST_SEG;
            end
            ST_SEG: begin
               if (!seg_valid) begin
                  cause_q     <= CAUSE_SEG;
                  fault_vaddr <= cur_vaddr;
                  state_q     <= ST_FAULT;
               end else if (vpage > seg_limit) begin
                  cause_q     <= CAUSE_BOUNDS;
                  fault_vaddr <= cur_vaddr;
                  state_q     <= ST_FAULT;
               end else begin
                  mem_addr <= pte_addr;
                  state_q  <= ST_PT_REQ;
               end
            end
            ST_PT_REQ, ST_PT_WAIT: begin
               if (mem_ack) begin
                  if (!mem_rdata[MEM_DW-1]) begin
                     cause_q     <= CAUSE_PAGE;
                     fault_vaddr <= cur_vaddr;
                     state_q     <= ST_FAULT;
                  end else begin
                     ppn     <= mem_rdata[MEM_DW-2:0];
                     state_q <= ST_DONE;
                  end
               end else begin
                  state_q <= ST_PT_WAIT;
               end
            end
            ST_DONE:  state_q <= ST_IDLE;
            ST_FAULT: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign ready       = (state_q == ST_IDLE);
   assign mem_req     = (state_q == ST_PT_REQ) || (state_q == ST_PT_WAIT);
   assign done        = (state_q == ST_DONE);
   assign fault       = (state_q == ST_FAULT);
   assign fault_cause = cause_q;

   // R4: request and address held until acknowledged
   a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
   // R7 R8: a segment or bounds failure never reaches the memory port
   a_r8_no_read_on_check_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEG && (!seg_valid || vpage > seg_limit)) |=> (fault && !mem_req));
   // R10: latched fault address moves only together with a fault pulse
   a_r10_fault_vaddr_held: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |=> (fault || $stable(fault_vaddr)));
   // R11: an accepted request makes the block busy
   a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req_valid) |=> !ready);
   // R13: single-cycle completion pulses, never both
   a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r13_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);
   a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fault, mem_req, ready}));
   // R13: done follows a sampled acknowledge by one cycle
   a_r13_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_rdata[MEM_DW-1]) |=> done);

   logic unused_w;
   assign unused_w = ^{VA_W};
endmodule

// File: rtl/segpage_xlat.sv
`timescale 1ns/1ps
module segpage_xlat #(
   parameter int SEG_W       = 2,
   parameter int PAGE_W      = 6,
   parameter int DISP_W      = 8,
   parameter int MEM_AW      = 16,
   parameter int MEM_DW      = 16,
   parameter int PTE_BYTES   = 2,
   parameter int FRAME_SHIFT = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           tbl_wr_en,
   input  logic [SEG_W-1:0]               tbl_wr_idx,
   input  logic [MEM_AW-1:0]              tbl_wr_base,
   input  logic [PAGE_W-1:0]              tbl_wr_limit,
   input  logic                           tbl_wr_valid,
   input  logic                           req_valid,
   input  logic [SEG_W+PAGE_W+DISP_W-1:0] req_vaddr,
   input  logic                           req_mode,
   output logic                           ready,
   output logic                           mem_req,
   output logic [MEM_AW-1:0]              mem_addr,
   input  logic                           mem_ack,
   input  logic [MEM_DW-1:0]              mem_rdata,
   output logic                           done,
   output logic [MEM_DW-1+DISP_W-1:0]     paddr,
   output logic                           fault,
   output logic [1:0]                     fault_cause,
   output logic [SEG_W+PAGE_W+DISP_W-1:0] fault_vaddr
);
   localparam int VA_W  = SEG_W + PAGE_W + DISP_W;
   localparam int PPN_W = MEM_DW - 1;

   if (SEG_W < 1 || PAGE_W < 1 || DISP_W < 1) begin : g_bad_fields
      $error("segpage_xlat: every address field needs at least one bit");
   end
   if (PTE_BYTES < 1) begin : g_bad_pte
      $error("segpage_xlat: PTE_BYTES must be positive");
   end
   if (FRAME_SHIFT > DISP_W) begin : g_bad_shift
      $error("segpage_xlat: FRAME_SHIFT may not exceed DISP_W");
   end
   if (MEM_DW < 2) begin : g_bad_dw
      $error("segpage_xlat: MEM_DW must hold a valid bit and a page number");
   end

   logic [VA_W-1:0]   cur_vaddr;
   logic              cur_mode;
   logic [MEM_AW-1:0] seg_base;
   logic [PAGE_W-1:0] seg_limit;
   logic              seg_valid;
   logic [MEM_AW-1:0] pte_addr;
   logic [PPN_W-1:0]  ppn;

   sp_seg_table #(
      .SEG_W (SEG_W),
      .PAGE_W(PAGE_W),
      .BASE_W(MEM_AW)
   ) i_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr_en),
      .wr_idx  (tbl_wr_idx),
      .wr_base (tbl_wr_base),
      .wr_limit(tbl_wr_limit),
      .wr_valid(tbl_wr_valid),
      .rd_idx  (cur_vaddr[VA_W-1 -: SEG_W]),
      .rd_base (seg_base),
      .rd_limit(seg_limit),
      .rd_valid(seg_valid)
   );

   sp_addr_calc #(
      .PAGE_W     (PAGE_W),
      .DISP_W     (DISP_W),
      .BASE_W     (MEM_AW),
      .PPN_W      (PPN_W),
      .PTE_BYTES  (PTE_BYTES),
      .FRAME_SHIFT(FRAME_SHIFT)
   ) i_calc (
      .pt_base (seg_base),
      .vpage   (cur_vaddr[DISP_W +: PAGE_W]),
      .disp    (cur_vaddr[DISP_W-1:0]),
      .ppn     (ppn),
      .add_mode(cur_mode),
      .pte_addr(pte_addr),
      .paddr   (paddr)
   );

   sp_walk_ctrl #(
      .SEG_W (SEG_W),
      .PAGE_W(PAGE_W),
      .DISP_W(DISP_W),
      .MEM_AW(MEM_AW),
      .MEM_DW(MEM_DW)
   ) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_vaddr  (req_vaddr),
      .req_mode   (req_mode),
      .seg_valid  (seg_valid),
      .seg_limit  (seg_limit),
      .pte_addr   (pte_addr),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .ready      (ready),
      .cur_vaddr  (cur_vaddr),
      .cur_mode   (cur_mode),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .ppn        (ppn),
      .done       (done),
      .fault      (fault),
      .fault_cause(fault_cause),
      .fault_vaddr(fault_vaddr)
   );
endmodule

// File: tb/test_segpage_xlat.sv
`timescale 1ns/1ps
module test_segpage_xlat;
   localparam int SEG_W = 2, PAGE_W = 6, DISP_W = 8, MEM_AW = 16, MEM_DW = 16;
   localparam int VA_W = SEG_W + PAGE_W + DISP_W;
   localparam int PA_W = MEM_DW - 1 + DISP_W;
   localparam logic [15:0] BAD_PTE = 16'h100A;  // seg0 base 0x1000, page 5

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tbl_wr_en = 1'b0;
   logic [SEG_W-1:0] tbl_wr_idx = '0;
   logic [MEM_AW-1:0] tbl_wr_base = '0;
   logic [PAGE_W-1:0] tbl_wr_limit = '0;
   logic tbl_wr_valid = 1'b0;
   logic req_valid = 1'b0;
   logic [VA_W-1:0] req_vaddr = '0;
   logic req_mode = 1'b0;
   logic ready, mem_req, done, fault;
   logic [MEM_AW-1:0] mem_addr;
   logic mem_ack = 1'b0;
   logic [MEM_DW-1:0] mem_rdata = '0;
   logic [PA_W-1:0] paddr;
   logic [1:0] fault_cause;
   logic [VA_W-1:0] fault_vaddr;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   segpage_xlat i_segpage_xlat (
      .clk(clk), .rst_n(rst_n),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_base(tbl_wr_base),
      .tbl_wr_limit(tbl_wr_limit), .tbl_wr_valid(tbl_wr_valid),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_mode(req_mode),
      .ready(ready), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .done(done), .paddr(paddr), .fault(fault),
      .fault_cause(fault_cause), .fault_vaddr(fault_vaddr)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] pte_of(input logic [15:0] a);
      if (a == BAD_PTE) return 16'h0000;
      return {1'b1, a[14:0] ^ 15'h2A5A};
   endfunction

   function automatic logic [PA_W-1:0] exp_pa(input logic [15:0] a, input logic [7:0] d,
                                              input bit mode);
      logic [14:0] p;
      p = a[14:0] ^ 15'h2A5A;
      if (mode) return PA_W'(p) * 16 + PA_W'(d);
      return {p, d};
   endfunction

   // results of the last walk
   bit r_done, r_fault, r_req_seen, r_stable;
   logic [PA_W-1:0] r_pa;
   logic [1:0] r_cause;
   logic [15:0] r_addr;
   int r_lat, r_pulses;

   task automatic tbl_write(input int idx, input logic [15:0] base, input int lim, input bit v);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_idx = SEG_W'(idx); tbl_wr_base = base;
      tbl_wr_limit = PAGE_W'(lim); tbl_wr_valid = v;
      @(negedge clk);
      tbl_wr_en = 1'b0;
   endtask

   // Issue one request and act as memory with 'waits' stall cycles.
   task automatic walk(input logic [VA_W-1:0] va, input bit mode, input int waits,
                       input int hold_extra);
      int wcnt, n;
      r_done = 0; r_fault = 0; r_req_seen = 0; r_stable = 1; r_pulses = 0; r_lat = 0;
      wcnt = 0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_mode = mode;
      n = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         n++;
         if (n > hold_extra) req_valid = 1'b0;
         else req_vaddr = ~va;  // altered address while busy
         if (mem_req) begin
            if (!r_req_seen) begin
               r_req_seen = 1; r_addr = mem_addr;
            end else if (mem_addr != r_addr) r_stable = 0;
            if (wcnt >= waits) begin
               mem_ack = 1'b1; mem_rdata = pte_of(mem_addr);
            end else begin
               mem_ack = 1'b0; wcnt++;
            end
         end else begin
            mem_ack = 1'b0;
         end
         if (done || fault) begin
            r_pulses++;
            if (!r_done && !r_fault) begin
               r_done = done; r_fault = fault; r_pa = paddr; r_cause = fault_cause;
               r_lat = n;
            end
         end
         if ((r_done || r_fault) && n > r_lat + 4 && n > hold_extra) break;
      end
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk(ready == 1'b1, "R1 ready", ready, 1);
      chk(!done && !fault && !mem_req, "R1 outputs idle", {done, fault, mem_req}, 0);
      chk(fault_cause == 2'd0, "R1 cause", fault_cause, 0);
   endtask

   task automatic t_concat();
      walk({2'd0, 6'd3, 8'h45}, 1'b0, 0, 0);
      chk(r_addr == 16'h1006, "R3 pte address", r_addr, 16'h1006);
      chk(r_done && r_pa == exp_pa(16'h1006, 8'h45, 0), "R5 concat paddr", r_pa,
          exp_pa(16'h1006, 8'h45, 0));
      chk(r_pulses == 1, "R13 single done", r_pulses, 1);
      chk(r_lat == 3, "R13 done latency", r_lat, 3);
   endtask

   task automatic t_add_wait();
      walk({2'd1, 6'd7, 8'hF3}, 1'b1, 4, 0);
      chk(r_addr == 16'h200E, "R3 pte address seg1", r_addr, 16'h200E);
      chk(r_stable, "R4 address held during waits", r_stable, 1);
      chk(r_lat == 7, "R4 R13 latency with waits", r_lat, 7);
      chk(r_done && r_pa == exp_pa(16'h200E, 8'hF3, 1), "R6 add paddr", r_pa,
          exp_pa(16'h200E, 8'hF3, 1));
   endtask

   task automatic t_limits();
      walk({2'd0, 6'd10, 8'h01}, 1'b0, 1, 0);
      chk(r_done && r_pa == exp_pa(16'h1014, 8'h01, 0), "R8 page at limit", r_pa,
          exp_pa(16'h1014, 8'h01, 0));
      walk({2'd0, 6'd11, 8'h02}, 1'b0, 0, 0);
      chk(r_fault && r_cause == 2'd2, "R8 bounds cause", r_cause, 2);
      chk(!r_req_seen, "R8 no read on bounds", r_req_seen, 0);
      chk(r_lat == 2, "R13 bounds latency", r_lat, 2);
      chk(fault_vaddr == {2'd0, 6'd11, 8'h02}, "R10 bounds vaddr", fault_vaddr,
          {2'd0, 6'd11, 8'h02});
   endtask

   task automatic t_seg_invalid();
      walk({2'd2, 6'd0, 8'h10}, 1'b0, 0, 0);
      chk(r_fault && r_cause == 2'd1, "R7 segment cause", r_cause, 1);
      chk(!r_req_seen, "R7 no read", r_req_seen, 0);
   endtask

   task automatic t_page_fault();
      walk({2'd0, 6'd5, 8'h77}, 1'b0, 2, 0);
      chk(r_req_seen && r_addr == BAD_PTE, "R9 read issued", r_addr, BAD_PTE);
      chk(r_fault && r_cause == 2'd3, "R9 page cause", r_cause, 3);
      chk(fault_vaddr == {2'd0, 6'd5, 8'h77}, "R10 page vaddr", fault_vaddr,
          {2'd0, 6'd5, 8'h77});
      walk({2'd1, 6'd1, 8'h00}, 1'b0, 0, 0);
      chk(r_done, "R10 clean walk", r_done, 1);
      chk(fault_vaddr == {2'd0, 6'd5, 8'h77}, "R10 held after success", fault_vaddr,
          {2'd0, 6'd5, 8'h77});
   endtask

   task automatic t_carry();
      logic [VA_W-1:0] va;
      va = {2'd0, 6'd63, 8'h20} + 16'h0100;  // page overflow carries into segment
      walk(va, 1'b0, 0, 0);
      chk(r_done && r_addr == 16'h2000, "R2 carry selects next segment", r_addr, 16'h2000);
      chk(r_pa == exp_pa(16'h2000, 8'h20, 0), "R2 carry paddr", r_pa,
          exp_pa(16'h2000, 8'h20, 0));
   endtask

   task automatic t_busy();
      walk({2'd1, 6'd2, 8'h33}, 1'b0, 1, 3);
      chk(r_pulses == 1, "R11 one completion only", r_pulses, 1);
      chk(r_addr == 16'h2004, "R11 first request used", r_addr, 16'h2004);
      chk(r_pa == exp_pa(16'h2004, 8'h33, 0), "R11 paddr", r_pa, exp_pa(16'h2004, 8'h33, 0));
      @(negedge clk);
      chk(ready && !mem_req, "R11 idle afterwards", {ready, mem_req}, 2);
   endtask

   task automatic t_rewrite();
      tbl_write(3, 16'h3000, 0, 1);
      walk({2'd3, 6'd1, 8'h00}, 1'b0, 0, 0);
      chk(r_fault && r_cause == 2'd2, "R12 small limit bounds", r_cause, 2);
      tbl_write(3, 16'h4400, 20, 1);
      walk({2'd3, 6'd1, 8'h09}, 1'b1, 0, 0);
      chk(r_done && r_addr == 16'h4402, "R12 new base used", r_addr, 16'h4402);
      chk(r_pa == exp_pa(16'h4402, 8'h09, 1), "R12 paddr", r_pa, exp_pa(16'h4402, 8'h09, 1));
   endtask

   initial begin
      #(5.0 * 100000);
      bad++; total++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      tbl_write(0, 16'h1000, 10, 1);
      tbl_write(1, 16'h2000, 63, 1);
      tbl_write(2, 16'h5000, 63, 0);
      t_concat();
      t_add_wait();
      t_limits();
      t_seg_invalid();
      t_page_fault();
      t_carry();
      t_busy();
      t_rewrite();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule